// File: doc/BRIEF.md
# DRAM Clock-Enable Power State Tracker

This block follows the power state of a graphics DRAM from the memory controller's side. At every rising clock edge it looks at the clock-enable level now and at the previous edge, the decoded command presented at this edge, and a flag that says whether any bank holds an open row. From these it moves between five states: all banks idle, banks active, precharge power-down, active power-down and self-refresh.

Any edge whose combination of clock-enable pair, state and command is not an allowed transition raises an illegal flag for one cycle and leaves the state where it was. When self-refresh ends, a down-counter opens a quiet window. For a parameterised number of edges only deselect or no-operation may be issued, with clock enable held high. A ready output shows when that window has closed.

The block is used as a protocol monitor next to a controller, or as the power-state front end of a memory model. All outputs are registered and change at the same rising edge that samples the inputs.

Top module: `cke_pwr_tracker`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `state_o` is 0 (idle), `illegal_o` is 0 and `ready_o` is 1. The clock enable seen at the edge before the first edge after reset is taken as high.
- R2: With clock enable low at both the previous and the current edge, states 2 (precharge power-down), 3 (active power-down) and 4 (self-refresh) are kept for any command, and no illegal flag is raised.
- R3: With clock enable low at the previous edge and high at the current edge, and command 0 (deselect) or 1 (no-operation), the block leaves power-down or self-refresh. State 2 goes to 0, state 3 goes to 1 (banks active) and state 4 goes to 0.
- R4: With clock enable high then low, a deselect or no-operation command and state 0 or 1, the block enters state 2 if `bank_act_i` is 0 and state 3 if it is 1.
- R5: With clock enable high then low, command 6 (auto-refresh), state 0 or 1 and `bank_act_i` 0, the block enters state 4. If `bank_act_i` is 1, the edge is illegal.
- R6: The edge that leaves self-refresh drives `ready_o` low. It stays low for the next `XSR_CYCLES` edges (default 200) and goes high at the edge that completes them.
- R7: While `ready_o` is low, an edge is illegal if its command is anything other than 0 or 1, or if clock enable falls at it.
- R8: Every combination not allowed by R2 to R5 and R9 sets `illegal_o` to 1 for exactly the cycle after that edge. The state is left unchanged by that edge. Examples: a low-to-high clock enable with command 2 (activate), or high-to-high clock enable while in a power-down state.
- R9: With clock enable high at both edges in state 0 or 1, on an edge not made illegal by R7, the state becomes 1 if `bank_act_i` is 1 and 0 otherwise, whatever the command (3 read, 4 write, 5 precharge, 7 mode set are decoded but act alike).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke_i | input | 1 | Clock-enable level at this edge |
| cmd_i | input | 3 | Decoded command: 0 deselect, 1 no-op, 2 activate, 3 read, 4 write, 5 precharge, 6 auto-refresh, 7 mode set |
| bank_act_i | input | 1 | High when any bank has an open row |
| state_o | output | 3 | 0 idle, 1 active, 2 precharge power-down, 3 active power-down, 4 self-refresh |
| illegal_o | output | 1 | One-cycle flag for a disallowed edge |
| ready_o | output | 1 | Low during the post-self-refresh quiet window |

## Verification
The stimulus runs through each clock-enable pair (low-low, low-high, high-low, high-high) with both the quiet commands and active ones. This separates legal entries and exits from the same pairs carrying a forbidden command. Power-down is entered with the bank flag at both values, and both power-down types are exited, which shows whether exit restores the matching idle or active state. Self-refresh is entered with the bank flag at both values, and the bank flag is also toggled while in high-high operation. The quiet window is walked edge by edge to its last step, first with only quiet commands and then with an activate and a falling clock enable inside it. This pins down the exact edge where ready rises and confirms that a violation does not change the state.

// File: rtl/cke_pwr_pkg.sv
package cke_pwr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ACTIVE = 3'd1,
        ST_PPD    = 3'd2,
        ST_APD    = 3'd3,
        ST_SREF   = 3'd4
    } pwr_state_e;

    typedef enum logic [2:0] {
        CMD_DESEL = 3'd0,
        CMD_NOP   = 3'd1,
        CMD_ACT   = 3'd2,
        CMD_RD    = 3'd3,
        CMD_WR    = 3'd4,
        CMD_PRE   = 3'd5,
        CMD_AREF  = 3'd6,
        CMD_MRS   = 3'd7
    } dram_cmd_e;

    typedef struct packed {
        pwr_state_e state;
        logic       illegal;
    } fsm_regs_t;

    function automatic logic is_quiet(input logic [2:0] c);
        return (c == CMD_DESEL) || (c == CMD_NOP);
    endfunction

    function automatic logic is_powered_down(input pwr_state_e s);
        return (s == ST_PPD) || (s == ST_APD) || (s == ST_SREF);
    endfunction

endpackage

// File: rtl/cke_history.sv
module cke_history (
    input  logic clk,
    input  logic rst_n,
    input  logic cke_i,
    output logic cke_prev_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = cke_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end

    assign cke_prev_o = prev_q;

    AST_PREV_TRACKS_CKE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke_i) |=> prev_q); // R1
endmodule

// File: rtl/xsr_window_timer.sv
module xsr_window_timer #(
    parameter int XSR_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic ready_o
);
    localparam int CNT_W = $clog2(XSR_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(XSR_CYCLES);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = CNT_LOAD;
        else if (cnt_q != '0)
            cnt_d = cnt_q - CNT_ONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign ready_o = (cnt_q == '0);

    AST_EXIT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !ready_o); // R6
    AST_WINDOW_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && !load_i) |=> (cnt_q == $past(cnt_q) - CNT_ONE)); // R6
endmodule

// File: rtl/cke_state_fsm.sv
module cke_state_fsm
    import cke_pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cke_prev_i,
    input  logic       cke_i,
    input  logic [2:0] cmd_i,
    input  logic       bank_act_i,
    input  logic       ready_i,
    output pwr_state_e state_o,
    output logic       illegal_o,
    output logic       sref_exit_o
);
    fsm_regs_t cur_q, nxt_d;
    logic      exit_d;
    logic      quiet;
    logic      awake;

    always_comb begin
        quiet  = is_quiet(cmd_i);
        awake  = (cur_q.state == ST_IDLE) || (cur_q.state == ST_ACTIVE);
        nxt_d  = '{state: cur_q.state, illegal: 1'b0};
        exit_d = 1'b0;
        unique case ({cke_prev_i, cke_i})
            2'b00: begin
                if (!is_powered_down(cur_q.state)) nxt_d.illegal = 1'b1;
            end
            2'b01: begin
                if (quiet && cur_q.state == ST_PPD)
                    nxt_d.state = ST_IDLE;
                else if (quiet && cur_q.state == ST_APD)
                    nxt_d.state = ST_ACTIVE;
                else if (quiet && cur_q.state == ST_SREF) begin
                    nxt_d.state = ST_IDLE;
                    exit_d      = 1'b1;
                end else
                    nxt_d.illegal = 1'b1;
            end
            2'b10: begin
                if (awake && ready_i && quiet)
                    nxt_d.state = bank_act_i ? ST_APD : ST_PPD;
                else if (awake && ready_i && cmd_i == CMD_AREF && !bank_act_i)
                    nxt_d.state = ST_SREF;
                else
                    nxt_d.illegal = 1'b1;
            end
            default: begin
                if (awake && (ready_i || quiet))
                    nxt_d.state = bank_act_i ? ST_ACTIVE : ST_IDLE;
                else
                    nxt_d.illegal = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '{state: ST_IDLE, illegal: 1'b0};
        else        cur_q <= nxt_d;
    end

    assign state_o     = cur_q.state;
    assign illegal_o   = cur_q.illegal;
    assign sref_exit_o = exit_d;

    AST_LOW_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_prev_i && !cke_i && is_powered_down(cur_q.state))
        |=> (cur_q.state == $past(cur_q.state)) && !cur_q.illegal); // R2
    AST_PD_ENTRY_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
        (cke_prev_i && !cke_i && ready_i && is_quiet(cmd_i) &&
         (cur_q.state == ST_IDLE || cur_q.state == ST_ACTIVE))
        |=> (cur_q.state == ($past(bank_act_i) ? ST_APD : ST_PPD))); // R4
    AST_ILLEGAL_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.illegal |-> (cur_q.state == $past(cur_q.state))); // R8
    AST_WINDOW_LOUD_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_i && cke_i && !is_quiet(cmd_i)) |=> cur_q.illegal); // R7
    AST_SREF_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cke_prev_i && !cke_i && cmd_i == CMD_AREF && bank_act_i) |=> cur_q.illegal); // R5
endmodule

// File: rtl/cke_pwr_tracker.sv
module cke_pwr_tracker
    import cke_pwr_pkg::*;
#(
    parameter int XSR_CYCLES = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cke_i,
    input  logic [2:0] cmd_i,
    input  logic       bank_act_i,
    output logic [2:0] state_o,
    output logic       illegal_o,
    output logic       ready_o
);
    logic       cke_prev;
    logic       sref_exit;
    logic       ready;
    pwr_state_e state;

    cke_history u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .cke_i      (cke_i),
        .cke_prev_o (cke_prev)
    );

    cke_state_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cke_prev_i  (cke_prev),
        .cke_i       (cke_i),
        .cmd_i       (cmd_i),
        .bank_act_i  (bank_act_i),
        .ready_i     (ready),
        .state_o     (state),
        .illegal_o   (illegal_o),
        .sref_exit_o (sref_exit)
    );

    xsr_window_timer #(.XSR_CYCLES(XSR_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (sref_exit),
        .ready_o (ready)
    );

    assign state_o = state;
    assign ready_o = ready;

    AST_SREF_EXIT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_SREF && !cke_prev && cke_i && is_quiet(cmd_i))
        |=> (state_o == ST_IDLE) && !ready_o); // R3
endmodule

// File: tb/tb_cke_pwr_tracker.sv
`timescale 1ns/1ps
module tb_cke_pwr_tracker;
    localparam int XSR = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke = 1'b1;
    logic [2:0] cmd = 3'd1;
    logic       bact = 1'b0;
    logic [2:0] state_o;
    logic       illegal_o;
    logic       ready_o;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [2:0] st;
        logic       ill;
        logic       rdy;
        string      tag;
    } exp_t;
    exp_t sb[$];

    logic [2:0] m_st = 3'd0;
    logic       m_prev = 1'b1;
    int         m_cnt = 0;

    always #2 clk = ~clk;

    cke_pwr_tracker #(.XSR_CYCLES(XSR)) dut (
        .clk(clk), .rst_n(rst_n), .cke_i(cke), .cmd_i(cmd), .bank_act_i(bact),
        .state_o(state_o), .illegal_o(illegal_o), .ready_o(ready_o)
    );

    task automatic compare(input exp_t e);
        checks++;
        if (state_o !== e.st || illegal_o !== e.ill || ready_o !== e.rdy) begin
            failures++;
            $display("FAIL %s: got st=%0d ill=%0b rdy=%0b exp st=%0d ill=%0b rdy=%0b",
                     e.tag, state_o, illegal_o, ready_o, e.st, e.ill, e.rdy);
        end
    endtask

    // driver: applies one edge worth of inputs and pushes the expected outputs
    task automatic step(input logic c, input logic [2:0] k, input logic b, input string tag);
        logic quiet, awake, win, ill, load;
        logic [2:0] nst;
        exp_t e;
        @(negedge clk);
        cke = c; cmd = k; bact = b;
        quiet = (k <= 3'd1);
        awake = (m_st <= 3'd1);
        win   = (m_cnt != 0);
        ill = 1'b0; load = 1'b0; nst = m_st;
        case ({m_prev, c})
            2'b00: if (m_st < 3'd2) ill = 1'b1;
            2'b01: begin
                if (quiet && m_st == 3'd2) nst = 3'd0;
                else if (quiet && m_st == 3'd3) nst = 3'd1;
                else if (quiet && m_st == 3'd4) begin nst = 3'd0; load = 1'b1; end
                else ill = 1'b1;
            end
            2'b10: begin
                if (awake && !win && quiet) nst = b ? 3'd3 : 3'd2;
                else if (awake && !win && k == 3'd6 && !b) nst = 3'd4;
                else ill = 1'b1;
            end
            default: begin
                if (awake && (!win || quiet)) nst = b ? 3'd1 : 3'd0;
                else ill = 1'b1;
            end
        endcase
        if (load) m_cnt = XSR;
        else if (m_cnt != 0) m_cnt = m_cnt - 1;
        m_st = nst;
        m_prev = c;
        e.st = nst; e.ill = ill; e.rdy = (m_cnt == 0); e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: compares one expected item after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) compare(sb.pop_front());
        end
    end

    initial begin
        #(4 * 20000);
        failures++;
        $display("FAIL watchdog: run did not finish, got running exp done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        exp_t r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        r.st = 3'd0; r.ill = 1'b0; r.rdy = 1'b1; r.tag = "R1";
        compare(r);

        // R1: previous clock enable taken high, so a first low edge enters power-down
        step(1'b0, 3'd1, 1'b0, "R1");
        step(1'b1, 3'd1, 1'b0, "R3");
        // R9: high-high follows the bank flag
        step(1'b1, 3'd2, 1'b1, "R9");
        step(1'b1, 3'd3, 1'b1, "R9");
        step(1'b1, 3'd5, 1'b0, "R9");
        // R4 active power-down, R2 hold, R3 exit to active
        step(1'b1, 3'd2, 1'b1, "R9");
        step(1'b0, 3'd0, 1'b1, "R4");
        step(1'b0, 3'd3, 1'b0, "R2");
        step(1'b0, 3'd7, 1'b1, "R2");
        step(1'b1, 3'd1, 1'b1, "R3");
        // R4 precharge power-down, R8 loud exit
        step(1'b1, 3'd5, 1'b0, "R9");
        step(1'b0, 3'd1, 1'b0, "R4");
        step(1'b0, 3'd4, 1'b0, "R2");
        step(1'b1, 3'd2, 1'b0, "R8");
        step(1'b0, 3'd1, 1'b0, "R8");
        step(1'b0, 3'd1, 1'b0, "R2");
        step(1'b1, 3'd0, 1'b0, "R3");
        // R5: refresh entry refused with an open bank
        step(1'b1, 3'd2, 1'b1, "R9");
        step(1'b0, 3'd6, 1'b1, "R5");
        step(1'b1, 3'd1, 1'b1, "R8");
        step(1'b1, 3'd5, 1'b0, "R9");
        // R5 self-refresh entry, R2 hold, R3/R6 exit and full quiet window
        step(1'b0, 3'd6, 1'b0, "R5");
        step(1'b0, 3'd2, 1'b1, "R2");
        step(1'b0, 3'd6, 1'b0, "R2");
        step(1'b1, 3'd1, 1'b0, "R3");
        for (int i = 0; i < XSR; i++) step(1'b1, (i % 2 == 0) ? 3'd1 : 3'd0, 1'b0, "R6");
        step(1'b1, 3'd2, 1'b1, "R9");
        step(1'b1, 3'd5, 1'b0, "R9");
        // R7: violations inside a second window
        step(1'b0, 3'd6, 1'b0, "R5");
        step(1'b1, 3'd1, 1'b0, "R3");
        step(1'b1, 3'd2, 1'b1, "R7");
        step(1'b0, 3'd1, 1'b0, "R7");
        step(1'b1, 3'd1, 1'b0, "R8");
        for (int i = 0; i < XSR; i++) step(1'b1, 3'd1, 1'b0, "R6");
        step(1'b1, 3'd2, 1'b1, "R7");
        step(1'b0, 3'd1, 1'b1, "R4");
        step(1'b1, 3'd1, 1'b1, "R3");
        repeat (3) @(posedge clk);
        #1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule